// File: doc/BRIEF.md
# DMA Interrupt Status and Summary Register

This block holds the interrupt status of a DMA engine. Four event pulse inputs (transmit done, transmit buffer unavailable, receive done, early receive) each set a raw status bit. Software clears these bits by writing 1 to them. A mask word picks which of the four raw bits may raise the normal interrupt summary.

The summary bit is sticky. It is set whenever an enabled raw bit is set. It stays set after its sources are gone. Software clears it by writing 1 to it, as a separate step from clearing the raw bits. The interrupt output mirrors the summary bit.

Two word addresses make up the register port. `sel = 0` selects the status word and `sel = 1` selects the mask word. Writes take effect at the clock edge. Reads are combinational.

Top module: `dma_irq_summary`

## Requirements
- R1: After reset the status word, the mask word and `irq_o` all read 0.
- R2: A pulse on `evt_i[0]`, `evt_i[1]`, `evt_i[2]` or `evt_i[3]` sets status bit 0, 2, 6 or 14 respectively. The bit is visible on the read port in the cycle after the pulse.
- R3: Writing 1 to one of those status bits clears it. Writing 0 to it leaves it unchanged.
- R4: When an event pulse and a clearing write reach the same raw bit in the same cycle, the bit ends up set.
- R5: The summary (status bit 16) sets on the same edge as an enabled raw bit. A raw bit whose mask bit (same position in the mask word) is 0 never sets the summary.
- R6: The summary stays set after every raw bit has been cleared, until bit 16 is itself written with 1.
- R7: Writing 1 to bit 16 clears the summary only if no enabled raw bit remains set after that write. Otherwise the summary still reads 1 after the write.
- R8: `irq_o` is high exactly when status bit 16 reads 1.
- R9: Only mask bits 0, 2, 6 and 14 are stored. Every other bit of the mask word, and every status bit other than 0, 2, 6, 14 and 16, reads 0.
- R10: Enabling a mask bit while its raw bit is already set raises the summary on the edge after the mask write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 4 | Event pulses: tx done, tx buffer unavailable, rx done, early rx |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 mask |
| wr_data | input | DW | Write data |
| rd_sel | input | 1 | Read target: 0 status, 1 mask |
| rd_data | output | DW | Read data |
| irq_o | output | 1 | Interrupt request, mirrors the summary |

## Verification
A summary register stuck at its old value shows up on `irq_o` and on status bit 16 at the first sample after the edge that should have changed it. A summary computed as a live OR would instead drop as soon as the raw bits are cleared, which breaks the sticky check. If the mask gating is lost, a masked event raises `irq_o` one cycle after the pulse. A wrong clear priority is caught by the combined event-and-clear case and the partial-clear case, on the next read of the status word.

// File: rtl/dma_irq_summary.sv
module dma_irq_summary #(
  parameter int DW      = 32,
  parameter int SUM_BIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    evt_i,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          irq_o
);
  localparam int NSRC = 4;
  localparam int unsigned SRC_POS [NSRC] = '{0, 2, 6, 14};

  logic [NSRC-1:0] raw_q, raw_d, msk_q, clr_raw, wsel;
  logic            sum_q, sum_d, sum_clr, pend;
  logic [DW-1:0]   stat_word, mask_word;

  wire st_wr = wr_en & ~wr_sel;
  wire mk_wr = wr_en & wr_sel;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign wsel[g]    = wr_data[SRC_POS[g]];
    assign clr_raw[g] = st_wr & wsel[g];

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> raw_q[g]);
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr && wr_data[SRC_POS[g]] && !evt_i[g] |=> !raw_q[g]);
  end

  assign raw_d   = evt_i | (raw_q & ~clr_raw);
  assign sum_clr = st_wr & wr_data[SUM_BIT];
  assign pend    = |(raw_d & msk_q);
  assign sum_d   = pend | (sum_q & ~sum_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      msk_q <= '0;
      sum_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      sum_q <= sum_d;
      if (mk_wr) msk_q <= wsel;
    end
  end

  always_comb begin
    stat_word = '0;
    mask_word = '0;
    for (int i = 0; i < NSRC; i++) begin
      stat_word[SRC_POS[i]] = raw_q[i];
      mask_word[SRC_POS[i]] = msk_q[i];
    end
    stat_word[SUM_BIT] = sum_q;
  end

  assign rd_data = rd_sel ? mask_word : stat_word;
  assign irq_o   = sum_q;

  p_rise_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_q) |-> |(raw_q & $past(msk_q)));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sum_q && !(wr_en && !wr_sel && wr_data[SUM_BIT]) |=> sum_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sum_clr && (evt_i == '0) && ((raw_q & msk_q & ~clr_raw) == '0) |=> !sum_q);
  p_irq_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (irq_o == rd_data[SUM_BIT]));
endmodule

// File: tb/dma_irq_summary_tb_top.sv
module dma_irq_summary_tb_top;
  localparam int DW = 32;
  localparam logic [DW-1:0] ALL = 32'h0000_4045;
  localparam logic [DW-1:0] SUM = 32'h0001_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    evt_i = '0;
  logic          wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          irq_o;
  int            errors = 0, checks = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  dma_irq_summary #(.DW(DW), .SUM_BIT(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq_o(irq_o));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic [3:0] ev, logic we, logic sel, logic [DW-1:0] d);
    @(negedge clk);
    evt_i = ev; wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    evt_i = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_chk(string req, logic sel, logic [DW-1:0] exp, logic irq_exp);
    rd_sel = sel; #1;
    check(req, rd_data, exp);
    check({req, " irq"}, {31'd0, irq_o}, {31'd0, irq_exp});
  endtask

  task automatic t_reset();
    rd_chk("R1 status", 1'b0, '0, 1'b0);
    rd_chk("R1 mask", 1'b1, '0, 1'b0);
  endtask

  task automatic t_raw();
    cyc(4'b1111, 1'b0, 1'b0, '0);
    rd_chk("R2 R5 all events masked", 1'b0, ALL, 1'b0);
    cyc('0, 1'b1, 1'b0, '0);
    rd_chk("R3 write zero", 1'b0, ALL, 1'b0);
    cyc('0, 1'b1, 1'b0, 32'h4);
    rd_chk("R3 clear bit2", 1'b0, 32'h4041, 1'b0);
    cyc('0, 1'b1, 1'b0, ALL);
    rd_chk("R3 clear all", 1'b0, '0, 1'b0);
  endtask

  task automatic t_mask();
    cyc('0, 1'b1, 1'b1, '1);
    rd_chk("R9 mask stored bits", 1'b1, ALL, 1'b0);
    cyc('0, 1'b1, 1'b1, 32'h40);
    rd_chk("R9 mask bit6", 1'b1, 32'h40, 1'b0);
  endtask

  task automatic t_sticky();
    cyc(4'b0100, 1'b0, 1'b0, '0);
    rd_chk("R5 R8 enabled event", 1'b0, 32'h0001_0040, 1'b1);
    cyc('0, 1'b1, 1'b0, 32'h40);
    rd_chk("R6 sticky", 1'b0, SUM, 1'b1);
    cyc('0, 1'b1, 1'b0, SUM);
    rd_chk("R7 clear summary", 1'b0, '0, 1'b0);
  endtask

  task automatic t_reassert();
    cyc(4'b0100, 1'b0, 1'b0, '0);
    cyc('0, 1'b1, 1'b0, SUM);
    rd_chk("R7 source still set", 1'b0, 32'h0001_0040, 1'b1);
    cyc('0, 1'b1, 1'b0, 32'h0001_0040);
    rd_chk("R7 joint clear", 1'b0, '0, 1'b0);
  endtask

  task automatic t_evt_wins();
    cyc(4'b0001, 1'b1, 1'b0, 32'h1);
    rd_chk("R4 event beats clear", 1'b0, 32'h1, 1'b0);
    cyc('0, 1'b1, 1'b0, 32'h1);
    rd_chk("R4 cleanup", 1'b0, '0, 1'b0);
  endtask

  task automatic t_late_mask();
    cyc(4'b1000, 1'b0, 1'b0, '0);
    rd_chk("R5 masked bit14", 1'b0, 32'h4000, 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h4000;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    rd_chk("R10 before", 1'b0, 32'h4000, 1'b0);
    @(negedge clk);
    rd_chk("R10 after", 1'b0, 32'h0001_4000, 1'b1);
    cyc('0, 1'b1, 1'b0, 32'h0001_4000);
    rd_chk("R7 R10 cleanup", 1'b0, '0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    t_mask();
    t_sticky();
    t_reassert();
    t_evt_wins();
    t_late_mask();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule